// File: doc/BRIEF.md
# Serial Flash Protection and Status Controller

This block holds the status byte and the write-protection state of a serial flash model with a 512K x 8 array. It sits behind a command interface that already delivers whole commands, one per cycle, marked by a valid strobe with an opcode, a data byte and an array address. It answers status reads and the identification read with bytes on a response port. It keeps the write-enable latch, three block-protect bits and a protect-enable bit, and it models a self-timed internal write with a busy period of a configurable number of cycles.

The array is divided into eight equal sectors. The block-protect bits lock nothing, the top eighth, the top quarter, the top half, or the whole array. A hardware lock combines an active-low protect pin with the protect-enable bit and, while it is active, freezes the protection settings. A combinational output tells whether the address on the address port may be written at this moment.

A three-state machine runs the block: IDLE (accepts commands), ID_TAIL (sends the second identification byte) and BUSY (internal write in progress). The transitions are: IDLE to ID_TAIL on an identification read; ID_TAIL to IDLE after one cycle; IDLE to BUSY on an accepted status write or array write; BUSY to IDLE when the busy timer expires, at which point a pending status write is applied and the write-enable latch clears.

Top module: `wp_status_ctrl`

## Requirements
- R1: Opcode 2 (read status) returns one byte on rsp_data with rsp_valid high in the cycle after it is sampled; outside BUSY the byte is bit 0 = 0 (ready), bit 1 = write-enable latch, bits 4:2 = block-protect bits BP2..BP0 (bit 4 = BP2), bits 6:5 = 0, bit 7 = protect-enable bit.
- R2: A status read sampled while the block is busy returns 0xFF.
- R3: The address on addr (19 bits) is locked when BP2..BP0 = 001 and addr >= 0x70000, = 010 and addr >= 0x60000, = 011 and addr >= 0x40000, or BP2 = 1 (all addresses); with 000 nothing is locked.
- R4: The hardware lock is active only when wprot_n is 0 and the protect-enable bit is 1; while it is active a status write (opcode 3) is refused: busy stays 0 and the protection bits do not change.
- R5: A status write (opcode 3) is accepted only when the write-enable latch is 1; it raises busy and, when busy ends, loads BP2..BP0 from cmd_data[4:2] and the protect-enable bit from cmd_data[7].
- R6: An array write (opcode 5) is accepted only when the write-enable latch is 1 and addr is not locked; it raises busy. A refused array write leaves busy at 0 and the latch unchanged.
- R7: Opcode 1 sets the write-enable latch; the latch clears when an internal write finishes.
- R8: An identification read (opcode 4) returns 0x1F in the cycle after it is sampled and 0x64 in the next cycle.
- R9: Every command other than a status read is ignored while busy; opcodes 0, 6 and 7 are ignored at all times; no command is taken while the second identification byte is sent.
- R10: wr_allowed is high exactly when the latch is 1, the block is not busy and addr is not locked, and follows addr in the same cycle.
- R11: After reset the latch, the protect-enable bit and the block-protect bits are 0, busy is 0 and no response is driven.
- R12: An accepted write keeps busy high for exactly BUSY_CYCLES clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, stands in for power-up |
| wprot_n | input | 1 | Active-low hardware write-protect pin |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 8 | Data byte of a status write |
| addr | input | 19 | Array address for writes and for wr_allowed |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| busy | output | 1 | Internal write in progress |
| wr_allowed | output | 1 | Address on addr may be written now |

## Verification
Responses to status reads and the first identification byte are due one cycle after the command is sampled, and the second identification byte one cycle later; the driver queues the expected bytes at the moment it issues the command and the monitor compares them 2 ns after each rising edge, treating any byte with an empty queue as a failure. Busy rises on the edge that samples an accepted write and is counted at each falling edge until it drops, which must take exactly BUSY_CYCLES samples. wr_allowed is combinational and is sampled 1 ns after the address changes; refused and ignored commands are checked by reading status and busy right after them.

// File: rtl/wps_pkg.sv
package wps_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_SET_WEL   = 3'd1,
        OP_RD_STATUS = 3'd2,
        OP_WR_STATUS = 3'd3,
        OP_RD_ID     = 3'd4,
        OP_ARRAY_WR  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ID_TAIL = 2'd1,
        ST_BUSY    = 2'd2
    } state_e;

    typedef enum logic {
        JOB_STATUS = 1'b0,
        JOB_ARRAY  = 1'b1
    } job_e;

    // Number of locked sectors (out of 2**sect_bits) for a protect code.
    function automatic int unsigned locked_count(input logic [2:0] bp,
                                                 input int unsigned sect_bits);
        int unsigned total;
        total = 1 << sect_bits;
        if (bp[2])
            return total;
        unique case (bp[1:0])
            2'b00:   return 0;
            2'b01:   return total / 8;
            2'b10:   return total / 4;
            default: return total / 2;
        endcase
    endfunction

endpackage

// File: rtl/wps_prot_decode.sv
module wps_prot_decode #(
    parameter int ADDR_W    = 19,
    parameter int SECT_BITS = 3
) (
    input  logic [2:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    import wps_pkg::*;

    localparam int SECTORS  = 1 << SECT_BITS;
    localparam int SECT_SZ  = ADDR_W - SECT_BITS;

    logic [ADDR_W:0] first_locked_addr;
    int unsigned     n_locked;

    always_comb begin
        n_locked          = locked_count(bp, SECT_BITS);
        first_locked_addr = (ADDR_W+1)'(SECTORS - n_locked) << SECT_SZ;
        locked            = (n_locked != 0) && ({1'b0, addr} >= first_locked_addr);
    end

endmodule

// File: rtl/wps_busy_timer.sv
module wps_busy_timer #(
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= CNT_W'(BUSY_CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0)
                run_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run_q && (cnt_q == '0);

endmodule

// File: rtl/wps_status_fmt.sv
module wps_status_fmt (
    input  logic       busy,
    input  logic       wel,
    input  logic [2:0] bp,
    input  logic       wpen,
    output logic [7:0] status
);
    always_comb begin
        if (busy)
            status = 8'hFF;
        else
            status = {wpen, 2'b00, bp, wel, 1'b0};
    end
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl #(
    parameter int         ADDR_W      = 19,
    parameter int         SECT_BITS   = 3,
    parameter int         BUSY_CYCLES = 64,
    parameter logic [7:0] MFR_CODE    = 8'h1F,
    parameter logic [7:0] DEV_CODE    = 8'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wprot_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        cmd_data,
    input  logic [ADDR_W-1:0] addr,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              busy,
    output logic              wr_allowed
);
    import wps_pkg::*;

    state_e     state_q, state_d;
    job_e       job_q;
    logic       wel_q;
    logic       wpen_q;
    logic [2:0] bp_q;
    logic [2:0] pend_bp_q;
    logic       pend_wpen_q;

    logic       addr_locked;
    logic       hw_lock;
    logic       timer_done;
    logic [7:0] status_byte;
    logic       in_idle;
    logic       take_wel, take_wsr, take_awr, take_id, take_rds, start_write;
    logic       unused_data_bits;

    assign unused_data_bits = ^{cmd_data[6:5], cmd_data[1:0]};

    wps_prot_decode #(
        .ADDR_W   (ADDR_W),
        .SECT_BITS(SECT_BITS)
    ) u_decode (
        .bp    (bp_q),
        .addr  (addr),
        .locked(addr_locked)
    );

    wps_busy_timer #(
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start_write),
        .done (timer_done)
    );

    wps_status_fmt u_fmt (
        .busy  (state_q == ST_BUSY),
        .wel   (wel_q),
        .bp    (bp_q),
        .wpen  (wpen_q),
        .status(status_byte)
    );

    // command qualification
    always_comb begin
        in_idle     = (state_q == ST_IDLE);
        hw_lock     = !wprot_n && wpen_q;
        take_wel    = in_idle && cmd_valid && (op_e'(cmd_op) == OP_SET_WEL);
        take_wsr    = in_idle && cmd_valid && (op_e'(cmd_op) == OP_WR_STATUS)
                      && wel_q && !hw_lock;
        take_awr    = in_idle && cmd_valid && (op_e'(cmd_op) == OP_ARRAY_WR)
                      && wel_q && !addr_locked;
        take_id     = in_idle && cmd_valid && (op_e'(cmd_op) == OP_RD_ID);
        take_rds    = (state_q != ST_ID_TAIL) && cmd_valid
                      && (op_e'(cmd_op) == OP_RD_STATUS);
        start_write = take_wsr || take_awr;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_id)
                    state_d = ST_ID_TAIL;
                else if (start_write)
                    state_d = ST_BUSY;
            end
            ST_ID_TAIL: state_d = ST_IDLE;
            ST_BUSY: begin
                if (timer_done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs and protection state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_data    <= 8'h00;
            wel_q       <= 1'b0;
            wpen_q      <= 1'b0;
            bp_q        <= 3'b000;
            pend_bp_q   <= 3'b000;
            pend_wpen_q <= 1'b0;
            job_q       <= JOB_ARRAY;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take_rds) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= status_byte;
                    end else if (take_id) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= MFR_CODE;
                    end
                    if (take_wel)
                        wel_q <= 1'b1;
                    if (take_wsr) begin
                        job_q       <= JOB_STATUS;
                        pend_bp_q   <= cmd_data[4:2];
                        pend_wpen_q <= cmd_data[7];
                    end else if (take_awr) begin
                        job_q <= JOB_ARRAY;
                    end
                end
                ST_ID_TAIL: begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= DEV_CODE;
                end
                ST_BUSY: begin
                    if (take_rds) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= status_byte;
                    end
                    if (timer_done) begin
                        wel_q <= 1'b0;
                        if (job_q == JOB_STATUS) begin
                            bp_q   <= pend_bp_q;
                            wpen_q <= pend_wpen_q;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy       = (state_q == ST_BUSY);
    assign wr_allowed = wel_q && (state_q != ST_BUSY) && !addr_locked;

endmodule

// File: rtl/wps_checker.sv
module wps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wprot_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       rsp_valid,
    input logic [7:0] rsp_data,
    input logic       busy,
    input logic       wr_allowed,
    input logic       idle,
    input logic       wel,
    input logic       wpen,
    input logic [2:0] bp,
    input logic [7:0] mfr,
    input logic [7:0] dev
);
    AST_BUSY_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_valid && cmd_op == 3'd2 |=> rsp_valid && rsp_data == 8'hFF); // R2

    AST_HW_LOCK_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !wprot_n && wpen && cmd_valid && cmd_op == 3'd3 |=> !busy); // R4

    AST_PROT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(bp) && $stable(wpen)); // R5

    AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R7

    AST_ID_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
        idle && cmd_valid && cmd_op == 3'd4 |=> rsp_valid && rsp_data == mfr ##1 rsp_valid && rsp_data == dev); // R8

    AST_NO_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allowed |-> wel && !busy); // R10

    AST_BUSY_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(idle) && $past(cmd_valid)); // R9

endmodule

bind wp_status_ctrl wps_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wprot_n   (wprot_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .busy      (busy),
    .wr_allowed(wr_allowed),
    .idle      (state_q == wps_pkg::ST_IDLE),
    .wel       (wel_q),
    .wpen      (wpen_q),
    .bp        (bp_q),
    .mfr       (MFR_CODE),
    .dev       (DEV_CODE)
);

// File: tb/wp_status_ctrl_bench.sv
module wp_status_ctrl_bench;
    localparam int BUSY_N = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wprot_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_data;
    logic [18:0] addr;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        busy;
    logic        wr_allowed;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    wp_status_ctrl #(.BUSY_CYCLES(BUSY_N)) u_wp_status_ctrl (
        .clk(clk), .rst_n(rst_n), .wprot_n(wprot_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .addr(addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
        .wr_allowed(wr_allowed)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // monitor: compare responses against the scoreboard queue
    always @(posedge clk) begin
        #2;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R9 unexpected response act=%0h exp=none", rsp_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                check(t, {24'h0, rsp_data}, {24'h0, e});
            end
        end
    end

    task automatic send(input logic [2:0] op, input logic [7:0] d, input logic [18:0] a);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        addr      = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic rd_status(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        send(3'd2, 8'h00, addr);
    endtask

    task automatic rd_id();
        exp_q.push_back(8'h1F); tag_q.push_back("R8 first byte");
        exp_q.push_back(8'h64); tag_q.push_back("R8 second byte");
        send(3'd4, 8'h00, addr);
        @(negedge clk);
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wsr(input logic [7:0] d);
        int n;
        send(3'd1, 8'h00, addr);
        send(3'd3, d, addr);
        wait_busy(n);
    endtask

    task automatic chk_allowed(input logic [18:0] a, input logic e, input string t);
        @(negedge clk);
        addr = a;
        #1;
        check(t, {31'h0, wr_allowed}, {31'h0, e});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0; wprot_n = 1'b1; cmd_valid = 1'b0;
        cmd_op = 3'd0; cmd_data = 8'h00; addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 busy", {31'h0, busy}, 32'h0);
        check("R11 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R11 wr_allowed", {31'h0, wr_allowed}, 32'h0);
        rd_status(8'h00, "R1 R11 status after reset");

        rd_id(); // R8

        // R5 status write refused without latch
        send(3'd3, 8'h9C, addr);
        check("R5 no latch busy", {31'h0, busy}, 32'h0);
        rd_status(8'h00, "R5 no latch status");

        // R7 latch set, R10 allowed
        send(3'd1, 8'h00, addr);
        rd_status(8'h02, "R7 latch set");
        chk_allowed(19'h00000, 1'b1, "R10 allowed with latch");

        // R2 / R9 during busy
        send(3'd3, 8'h04, addr);
        check("R5 accepted busy", {31'h0, busy}, 32'h1);
        check("R10 blocked while busy", {31'h0, wr_allowed}, 32'h0);
        rd_status(8'hFF, "R2 busy status");
        send(3'd4, 8'h00, addr);        // R9 ignored, no response queued
        send(3'd3, 8'h1C, addr);        // R9 ignored
        wait_busy(n);
        rd_status(8'h04, "R5 R7 R9 after status write");

        // R3 protect levels
        send(3'd1, 8'h00, addr);
        chk_allowed(19'h6FFFF, 1'b1, "R3 eighth below");
        chk_allowed(19'h70000, 1'b0, "R3 eighth start");
        chk_allowed(19'h7FFFF, 1'b0, "R3 eighth top");

        // R6 array writes
        send(3'd5, 8'h00, 19'h70000);
        check("R6 locked write busy", {31'h0, busy}, 32'h0);
        rd_status(8'h06, "R6 latch kept");
        send(3'd5, 8'h00, 19'h12345);
        wait_busy(n);
        check("R12 busy length", n, BUSY_N);
        rd_status(8'h04, "R6 R7 after array write");

        wsr(8'h08);
        send(3'd1, 8'h00, addr);
        chk_allowed(19'h5FFFF, 1'b1, "R3 quarter below");
        chk_allowed(19'h60000, 1'b0, "R3 quarter start");
        wsr(8'h0C);
        send(3'd1, 8'h00, addr);
        chk_allowed(19'h3FFFF, 1'b1, "R3 half below");
        chk_allowed(19'h40000, 1'b0, "R3 half start");
        wsr(8'h10);
        send(3'd1, 8'h00, addr);
        chk_allowed(19'h00000, 1'b0, "R3 all bottom");
        wsr(8'h1C);
        send(3'd1, 8'h00, addr);
        chk_allowed(19'h00000, 1'b0, "R3 all 111");
        rd_status(8'h1E, "R1 all bits");
        wsr(8'h00);
        send(3'd1, 8'h00, addr);
        chk_allowed(19'h7FFFF, 1'b1, "R3 none");

        // R4 hardware lock
        wsr(8'h80);
        rd_status(8'h80, "R4 wpen set");
        wprot_n = 1'b0;
        send(3'd1, 8'h00, addr);
        send(3'd3, 8'h1C, addr);
        check("R4 refused busy", {31'h0, busy}, 32'h0);
        rd_status(8'h82, "R4 refused status");
        chk_allowed(19'h7FFFF, 1'b1, "R4 array still open");
        wprot_n = 1'b1;
        send(3'd3, 8'h04, addr);
        check("R4 pin high accepts", {31'h0, busy}, 32'h1);
        wait_busy(n);
        rd_status(8'h04, "R4 after unlock");

        // R9 unused opcodes
        send(3'd1, 8'h00, addr);
        send(3'd6, 8'hFF, addr);
        send(3'd7, 8'hFF, addr);
        send(3'd0, 8'hFF, addr);
        check("R9 unused ops busy", {31'h0, busy}, 32'h0);
        rd_status(8'h06, "R9 unused ops status");

        repeat (3) @(negedge clk);
        check("R1 queue drained", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule